// File: doc/BRIEF.md
# Per-Phase Audio Sample Queues with Threshold Status

This block sits between a processor-side command port and the sample interface of a stereo audio serializer. It keeps four sample queues, one receive queue and one transmit queue for each of the two frame phases (left = phase 0, right = phase 1). Each queue can be switched on or off on its own. Each queue has its own programmable watermark. The serializer pushes received samples and pulls samples to transmit. The processor pulls received samples and pushes samples to transmit through single-cycle commands.

Each phase has a five-bit status word and a five-bit interrupt-enable mask with the same encoding. The "receive full" and "transmit empty" bits follow the watermarks, not physical occupancy. The overrun, underrun and framing-error bits are sticky and are cleared by writing ones. A single interrupt output combines both phases. The fill level of any queue can be read back through a phase and direction selector.

Command codes on `cmdCode`: 1 queue-on, 2 queue-off, 3 set-watermark, 4 irq-enable, 5 irq-disable, 6 clear-sticky, 7 push-transmit, 8 pop-receive. All other codes do nothing. Each command acts on `cmdPhase`. Direction bit values are 0 for receive and 1 for transmit.

Top module: `audio_phase_fifo`

## Requirements
- R1: After reset all queues are off and empty, every watermark is 8, both status words and both masks are zero, and `irq` is low.
- R2: Queue-on sets, and queue-off clears, the enables selected by `cmdData` bit 0 (receive) and bit 1 (transmit). `fifoEn` bit index is phase*2+direction. Queue-off empties the queue. A receive queue that is off ignores samples. A transmit queue that is off supplies zero and raises no flag.
- R3: Set-watermark accepts values 1 to 16 for the queue picked by `cmdPhase`/`cmdDir`. A value above 16 raises `thrOvfErr`, and a value below 1 raises `thrUnfErr`. Either error pulse lasts the one cycle after the command. A rejected value leaves the watermark unchanged.
- R4: Status bit 0 (0x01, receive full) is high while the receive queue is on and its level is at or above its watermark.
- R5: Status bit 1 (0x02, transmit empty) is high while the transmit queue is on and its level is at or below its watermark.
- R6: A sample that reaches an enabled receive queue holding 16 entries is dropped and sets sticky bit 2 (0x04, overrun).
- R7: A pull from an enabled, empty transmit queue returns zero and sets sticky bit 3 (0x08, underrun).
- R8: A `frameErr` pulse sets sticky bit 4 (0x10) of the phase given by `frameErrPhase`.
- R9: Clear-sticky clears the sticky bits of the phase that are marked 1 in `cmdData` bits 4:2. The live bits 1:0 are not affected.
- R10: Irq-enable sets, and irq-disable clears, the mask bits marked 1 in `cmdData` bits 4:0 for the phase.
- R11: `irq` is high exactly when some status bit of either phase is high and its mask bit is high.
- R12: Each queue returns samples in arrival order. `lvlOut` shows the level of the queue picked by `lvlPhase`/`lvlDir`.
- R13: `statusWord` and `irqMask` carry phase 0 in bits 4:0 and phase 1 in bits 9:5. Events on one phase leave the other phase's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdCode | input | 4 | Command code |
| cmdPhase | input | 1 | Phase the command acts on |
| cmdDir | input | 1 | Direction for set-watermark |
| cmdData | input | 32 | Command operand or transmit sample |
| cpuRxData | output | 32 | Head of the receive queue of `cmdPhase` |
| thrOvfErr | output | 1 | Watermark-too-large pulse |
| thrUnfErr | output | 1 | Watermark-too-small pulse |
| rxValid | input | 1 | Serializer delivers a received sample |
| rxPhase | input | 1 | Phase of the received sample |
| rxSample | input | 32 | Received sample |
| txReq | input | 1 | Serializer pulls a transmit sample |
| txPhase | input | 1 | Phase of the pull |
| txSample | output | 32 | Sample supplied in the pull cycle |
| frameErr | input | 1 | Framing error pulse from the serializer |
| frameErrPhase | input | 1 | Phase of the framing error |
| lvlPhase | input | 1 | Level readback phase select |
| lvlDir | input | 1 | Level readback direction select |
| lvlOut | output | 5 | Selected queue level |
| fifoEn | output | 4 | Queue enables, index phase*2+direction |
| statusWord | output | 10 | Status of both phases |
| irqMask | output | 10 | Interrupt masks of both phases |
| irq | output | 1 | Combined interrupt |

## Verification
The main check sweeps a table of watermarks: zero, values in range on both sides of a fixed level of five, the bounds 1 and 16, and values above 16. This shows whether the full bit follows the watermark rather than the queue depth, and whether a rejected value really leaves the previous watermark in force. Directed sequences then fill a receive queue past physical capacity and drain a transmit queue below zero, telling live flags apart from sticky ones. The clear-sticky step uses an all-ones pattern, so a clear that wrongly reaches the live bits shows up. Framing errors and masks are then exercised on the other phase, which shows whether one phase's bits can reach the other's.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
  localparam int NUM_Q = 4;          // phase*2 + direction
  localparam int ST_W = 5;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_Q_ON     = 4'd1,
    CMD_Q_OFF    = 4'd2,
    CMD_SET_THR  = 4'd3,
    CMD_IRQ_ON   = 4'd4,
    CMD_IRQ_OFF  = 4'd5,
    CMD_CLR      = 4'd6,
    CMD_PUSH_TX  = 4'd7,
    CMD_POP_RX   = 4'd8
  } cmd_e;

  typedef struct packed {
    logic [NUM_Q-1:0] push;
    logic [NUM_Q-1:0] pop;
    logic [NUM_Q-1:0] flush;
  } q_strobe_t;
endpackage

// File: rtl/audfifo_dp.sv
module audfifo_dp
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW = 32,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  q_strobe_t     stb,
  input  logic [DW-1:0] rxData,
  input  logic [DW-1:0] txWrData,
  output logic [LW-1:0] lvl  [NUM_Q],
  output logic [DW-1:0] head [NUM_Q]
);
  localparam int AW = $clog2(DEPTH);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wrPtr, rdPtr;
    logic [LW-1:0] cnt;
    logic [DW-1:0] wrData;

    // even queues receive from the serializer, odd queues from the processor
    if (q % 2 == 0) begin : g_rx
      assign wrData = rxData;
    end else begin : g_tx
      assign wrData = txWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else if (stb.flush[q]) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (stb.push[q]) wrPtr <= wrPtr + 1'b1;
        if (stb.pop[q])  rdPtr <= rdPtr + 1'b1;
        cnt <= cnt + LW'(stb.push[q]) - LW'(stb.pop[q]);
      end
    end

    always_ff @(posedge clk) begin
      if (stb.push[q] && !stb.flush[q]) mem[wrPtr] <= wrData;
    end

    assign lvl[q]  = cnt;
    assign head[q] = mem[rdPtr];

    a_r12_level_bound: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= LW'(DEPTH));
    a_r12_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
      stb.pop[q] |-> cnt != '0);
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
      stb.push[q] |-> cnt != LW'(DEPTH));
    a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
      stb.flush[q] |=> cnt == '0);
  end
endmodule

// File: rtl/audfifo_ctrl.sv
module audfifo_ctrl
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW = 32,
  parameter int LW = $clog2(DEPTH + 1),
  parameter int MIN_THR = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [3:0]    cmdCode,
  input  logic          cmdPhase,
  input  logic          cmdDir,
  input  logic [DW-1:0] cmdData,
  input  logic          rxValid,
  input  logic          rxPhase,
  input  logic          txReq,
  input  logic          txPhase,
  input  logic          frameErr,
  input  logic          frameErrPhase,
  input  logic [LW-1:0] lvl [NUM_Q],
  output q_strobe_t     stb,
  output logic          txServe,
  output logic          thrOvf,
  output logic          thrUnf,
  output logic [NUM_Q-1:0]  fifoEn,
  output logic [2*ST_W-1:0] statusWord,
  output logic [2*ST_W-1:0] irqMask,
  output logic          irq
);
  cmd_e cmd;
  logic [1:0] rIdx, tIdx, cIdx, cRx, cTx;
  logic [NUM_Q-1:0] en;
  logic [LW-1:0] thr [NUM_Q];
  logic [ST_W-1:0] mask [2];
  logic [2:0] sticky [2];      // [0] overrun, [1] underrun, [2] framing
  logic [1:0] ovrEvt, unrEvt;

  assign cmd  = cmd_e'(cmdCode);
  assign rIdx = {rxPhase, 1'b0};
  assign tIdx = {txPhase, 1'b1};
  assign cIdx = {cmdPhase, cmdDir};
  assign cRx  = {cmdPhase, 1'b0};
  assign cTx  = {cmdPhase, 1'b1};

  always_comb begin
    stb = '0;
    ovrEvt = '0;
    unrEvt = '0;
    txServe = 1'b0;
    if (rxValid && en[rIdx]) begin
      if (lvl[rIdx] == LW'(DEPTH)) ovrEvt[rxPhase] = 1'b1;
      else stb.push[rIdx] = 1'b1;
    end
    if (txReq && en[tIdx]) begin
      if (lvl[tIdx] == '0) unrEvt[txPhase] = 1'b1;
      else begin
        stb.pop[tIdx] = 1'b1;
        txServe = 1'b1;
      end
    end
    if (cmdValid) begin
      case (cmd)
        CMD_Q_OFF: begin
          stb.flush[cRx] = cmdData[0];
          stb.flush[cTx] = cmdData[1];
        end
        CMD_PUSH_TX: if (en[cTx] && lvl[cTx] != LW'(DEPTH)) stb.push[cTx] = 1'b1;
        CMD_POP_RX:  if (en[cRx] && lvl[cRx] != '0) stb.pop[cRx] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= '0;
      thrOvf <= 1'b0;
      thrUnf <= 1'b0;
      for (int q = 0; q < NUM_Q; q++) thr[q] <= LW'(DEPTH / 2);
      for (int p = 0; p < 2; p++) begin
        mask[p] <= '0;
        sticky[p] <= '0;
      end
    end else begin
      thrOvf <= 1'b0;
      thrUnf <= 1'b0;
      for (int p = 0; p < 2; p++) begin
        logic [2:0] clr;
        clr = (cmdValid && cmd == CMD_CLR && cmdPhase == p[0]) ? cmdData[4:2] : 3'b0;
        sticky[p] <= (sticky[p] & ~clr) | {frameErr && frameErrPhase == p[0], unrEvt[p], ovrEvt[p]};
      end
      if (cmdValid) begin
        case (cmd)
          CMD_Q_ON: begin
            if (cmdData[0]) en[cRx] <= 1'b1;
            if (cmdData[1]) en[cTx] <= 1'b1;
          end
          CMD_Q_OFF: begin
            if (cmdData[0]) en[cRx] <= 1'b0;
            if (cmdData[1]) en[cTx] <= 1'b0;
          end
          CMD_SET_THR: begin
            if (cmdData > DW'(DEPTH)) thrOvf <= 1'b1;
            else if (cmdData < DW'(MIN_THR)) thrUnf <= 1'b1;
            else thr[cIdx] <= cmdData[LW-1:0];
          end
          CMD_IRQ_ON:  mask[cmdPhase] <= mask[cmdPhase] | cmdData[ST_W-1:0];
          CMD_IRQ_OFF: mask[cmdPhase] <= mask[cmdPhase] & ~cmdData[ST_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_st
    localparam int RQ = 2 * p;
    localparam int TQ = 2 * p + 1;
    logic rxFull, txEmpty;
    assign rxFull  = en[RQ] && lvl[RQ] >= thr[RQ];
    assign txEmpty = en[TQ] && lvl[TQ] <= thr[TQ];
    assign statusWord[p*ST_W +: ST_W] = {sticky[p], txEmpty, rxFull};
    assign irqMask[p*ST_W +: ST_W] = mask[p];

    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
      sticky[p][0] && !(cmdValid && cmd == CMD_CLR && cmdPhase == p[0]) |=> sticky[p][0]);
    a_r7_underrun_sets: assert property (@(posedge clk) disable iff (!rstN)
      txReq && txPhase == p[0] && en[TQ] && lvl[TQ] == '0 |=> sticky[p][1]);
  end

  assign fifoEn = en;
  assign irq = |(statusWord & irqMask);

  a_r3_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(thrOvf && thrUnf));
  a_r3_err_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (thrOvf || thrUnf) |-> $past(cmdValid) && $past(cmdCode) == CMD_SET_THR);
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    irqMask == '0 |-> !irq);
endmodule

// File: rtl/audio_phase_fifo.sv
module audio_phase_fifo
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW = 32,
  parameter int MIN_THR = 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [3:0]    cmdCode,
  input  logic          cmdPhase,
  input  logic          cmdDir,
  input  logic [DW-1:0] cmdData,
  output logic [DW-1:0] cpuRxData,
  output logic          thrOvfErr,
  output logic          thrUnfErr,
  input  logic          rxValid,
  input  logic          rxPhase,
  input  logic [DW-1:0] rxSample,
  input  logic          txReq,
  input  logic          txPhase,
  output logic [DW-1:0] txSample,
  input  logic          frameErr,
  input  logic          frameErrPhase,
  input  logic          lvlPhase,
  input  logic          lvlDir,
  output logic [LW-1:0] lvlOut,
  output logic [NUM_Q-1:0]  fifoEn,
  output logic [2*ST_W-1:0] statusWord,
  output logic [2*ST_W-1:0] irqMask,
  output logic          irq
);
  q_strobe_t stb;
  logic [LW-1:0] lvl [NUM_Q];
  logic [DW-1:0] head [NUM_Q];
  logic txServe;

  audfifo_ctrl #(.DEPTH(DEPTH), .DW(DW), .LW(LW), .MIN_THR(MIN_THR)) i_ctrl (
    .clk, .rstN, .cmdValid, .cmdCode, .cmdPhase, .cmdDir, .cmdData,
    .rxValid, .rxPhase, .txReq, .txPhase, .frameErr, .frameErrPhase,
    .lvl, .stb, .txServe, .thrOvf(thrOvfErr), .thrUnf(thrUnfErr),
    .fifoEn, .statusWord, .irqMask, .irq
  );

  audfifo_dp #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) i_dp (
    .clk, .rstN, .stb, .rxData(rxSample), .txWrData(cmdData), .lvl, .head
  );

  assign txSample  = txServe ? head[{txPhase, 1'b1}] : '0;
  assign cpuRxData = head[{cmdPhase, 1'b0}];
  assign lvlOut    = lvl[{lvlPhase, lvlDir}];
endmodule

// File: tb/test_audio_phase_fifo.sv
`timescale 1ns/1ps
module test_audio_phase_fifo;
  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdPhase = 0, cmdDir = 0;
  logic [3:0] cmdCode = 0;
  logic [31:0] cmdData = 0, cpuRxData, rxSample = 0, txSample;
  logic thrOvfErr, thrUnfErr, rxValid = 0, rxPhase = 0, txReq = 0, txPhase = 0;
  logic frameErr = 0, frameErrPhase = 0, lvlPhase = 0, lvlDir = 0, irq;
  logic [4:0] lvlOut;
  logic [3:0] fifoEn;
  logic [9:0] statusWord, irqMask;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  audio_phase_fifo i_audio_phase_fifo (.*);

  // {watermark, expected overflow error, expected underflow error, expected full at level 5}
  localparam logic [10:0] VEC [8] = '{
    {8'd0,   1'b0, 1'b1, 1'b0},
    {8'd17,  1'b1, 1'b0, 1'b0},
    {8'd4,   1'b0, 1'b0, 1'b1},
    {8'd5,   1'b0, 1'b0, 1'b1},
    {8'd6,   1'b0, 1'b0, 1'b0},
    {8'd1,   1'b0, 1'b0, 1'b1},
    {8'd100, 1'b1, 1'b0, 1'b1},
    {8'd16,  1'b0, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doCmd(logic [3:0] code, logic ph, logic dir, logic [31:0] dat);
    @(negedge clk);
    cmdValid = 1; cmdCode = code; cmdPhase = ph; cmdDir = dir; cmdData = dat;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic rxPush(logic ph, logic [31:0] dat);
    @(negedge clk);
    rxValid = 1; rxPhase = ph; rxSample = dat;
    @(negedge clk);
    rxValid = 0;
  endtask

  task automatic txPull(logic ph, output logic [31:0] got);
    @(negedge clk);
    txReq = 1; txPhase = ph;
    #1 got = txSample;
    @(negedge clk);
    txReq = 0;
  endtask

  task automatic popRx(logic ph, output logic [31:0] got);
    @(negedge clk);
    cmdValid = 1; cmdCode = 4'd8; cmdPhase = ph;
    #1 got = cpuRxData;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic level(logic ph, logic dir, output logic [4:0] l);
    lvlPhase = ph; lvlDir = dir;
    #1 l = lvlOut;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [4:0] l;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(statusWord), 0);
    chk("R1 mask", 32'(irqMask), 0);
    chk("R1 enables", 32'(fifoEn), 0);
    chk("R1 irq", 32'(irq), 0);
    level(0, 0, l); chk("R1 level", 32'(l), 0);
    // R2 disabled receive queue ignores samples
    rxPush(0, 32'h55);
    level(0, 0, l); chk("R2 off queue ignores", 32'(l), 0);
    doCmd(4'd1, 0, 0, 32'd3);
    chk("R2 enable mask", 32'(fifoEn), 32'b0011);
    chk("R5 empty tx live", 32'(statusWord), 32'h002);
    for (int i = 0; i < 5; i++) rxPush(0, 32'hA0 + 32'(i));
    level(0, 0, l); chk("R12 level 5", 32'(l), 5);
    chk("R4 below default mark", 32'(statusWord[0]), 0);
    // R3/R4 watermark table
    foreach (VEC[k]) begin
      doCmd(4'd3, 0, 0, 32'(VEC[k][10:3]));
      chk($sformatf("R3 ovf thr=%0d", VEC[k][10:3]), 32'(thrOvfErr), 32'(VEC[k][2]));
      chk($sformatf("R3 unf thr=%0d", VEC[k][10:3]), 32'(thrUnfErr), 32'(VEC[k][1]));
      chk($sformatf("R4 full thr=%0d", VEC[k][10:3]), 32'(statusWord[0]), 32'(VEC[k][0]));
    end
    for (int i = 5; i < 16; i++) rxPush(0, 32'hA0 + 32'(i));
    chk("R4 full at 16", 32'(statusWord[0]), 1);
    rxPush(0, 32'hFF);
    level(0, 0, l); chk("R6 dropped", 32'(l), 16);
    chk("R6 overrun status", 32'(statusWord), 32'h007);
    chk("R11 no mask no irq", 32'(irq), 0);
    doCmd(4'd4, 0, 0, 32'h04);
    chk("R10 mask set", 32'(irqMask), 32'h004);
    chk("R11 irq high", 32'(irq), 1);
    doCmd(4'd5, 0, 0, 32'h04);
    chk("R10 mask clear", 32'(irqMask), 0);
    chk("R11 irq low", 32'(irq), 0);
    popRx(0, got); chk("R12 order first", got, 32'hA0);
    popRx(0, got); chk("R12 order second", got, 32'hA1);
    level(0, 0, l); chk("R12 level after pops", 32'(l), 14);
    doCmd(4'd6, 0, 0, 32'h1F);
    chk("R9 sticky cleared live kept", 32'(statusWord), 32'h002);
    // transmit side
    doCmd(4'd3, 0, 1, 32'd2);
    doCmd(4'd7, 0, 0, 32'h11);
    doCmd(4'd7, 0, 0, 32'h22);
    doCmd(4'd7, 0, 0, 32'h33);
    level(0, 1, l); chk("R12 tx level", 32'(l), 3);
    chk("R5 above mark", 32'(statusWord[1]), 0);
    txPull(0, got); chk("R12 tx first", got, 32'h11);
    chk("R5 at mark", 32'(statusWord[1]), 1);
    txPull(0, got); chk("R12 tx second", got, 32'h22);
    txPull(0, got); chk("R12 tx third", got, 32'h33);
    txPull(0, got); chk("R7 underrun zero", got, 0);
    chk("R7 underrun status", 32'(statusWord), 32'h00A);
    // other phase
    @(negedge clk); frameErr = 1; frameErrPhase = 1;
    @(negedge clk); frameErr = 0;
    chk("R8 R13 framing phase1", 32'(statusWord), 32'h20A);
    doCmd(4'd4, 1, 0, 32'h10);
    chk("R13 mask phase1", 32'(irqMask), 32'h200);
    chk("R11 irq phase1", 32'(irq), 1);
    doCmd(4'd6, 1, 0, 32'h10);
    chk("R9 phase1 cleared", 32'(statusWord), 32'h00A);
    chk("R11 irq cleared", 32'(irq), 0);
    // disable with flush
    doCmd(4'd2, 0, 0, 32'd1);
    chk("R2 disable", 32'(fifoEn), 32'b0010);
    level(0, 0, l); chk("R2 flush", 32'(l), 0);
    rxPush(0, 32'h77);
    level(0, 0, l); chk("R2 off after flush", 32'(l), 0);
    txPull(1, got); chk("R2 off tx zero", got, 0);
    chk("R2 off tx no flag", 32'(statusWord), 32'h00A);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule